// File: doc/BRIEF.md
# Two-Group Rotating Bus Arbiter

This block is the central arbiter of a shared parallel bus. It decides which of several masters may drive the bus: a number of external masters plus the local bridge master, which always sits at index 0. Requests and grants are active low. The bus-activity strobes FRAME# (`frameN`) and IRDY# (`irdyN`) tell the arbiter when a transaction starts and whether the bus is busy. A per-master priority mask, held in a control register outside this block, puts each master in either a high group or a low group.

Each group keeps its own rotation pointer. When both groups have pending requests, the arbiter alternates between them. With the usual setting (only the local master in the high group), the local master therefore wins every other transaction. Priorities move only when a new transaction starts. Between those points, the arbiter follows the highest-priority live request. A master that is granted but never starts is timed out and locked out. When no one asks for the bus, the grant stays with the last owner.

Top module: `dual_group_arbiter`

## Requirements
- R1: `gntN` is active low. At most one of its bits is low in any cycle.
- R2: Reset grants the bus to the local master only (`gntN` has only bit 0 low).
- R3: The grant goes to the highest-priority eligible request. Eligible means the request is low and the master is not locked out. If a higher-priority request appears, the grant moves to it at the next clock edge.
- R4: When both groups have eligible requests, the group that did not start the last transaction wins. A group that started means the master starting it was in that group. The group whose turn it is at reset is the high group (mask bit 1).
- R5: A transaction start is sampled as `frameN` low at a clock edge where it was high at the previous edge, with a grant active. At that point the granted master becomes lowest in its group. The next index above it, wrapping modulo the master count, becomes highest.
- R6: When all masters share one group, arbitration is a plain round robin over indices.
- R7: A master times out if its grant and request are both low and the bus is idle for 16 consecutive clock edges with no transaction start. Its grant is then removed. It gets no grant again until its request has been high at one clock edge.
- R8: On an idle bus (`frameN` and `irdyN` both high), moving the grant to another master first leaves all grants high for one cycle.
- R9: On a busy bus (`frameN` or `irdyN` low), the grant moves from one master to another in the same clock edge.
- R10: With no eligible request, an active grant stays where it is (bus parked at the last owner).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqN | input | NUM_EXT+1 | Request per master, active low; bit 0 is the local master |
| frameN | input | 1 | Transaction-frame strobe, active low |
| irdyN | input | 1 | Initiator-ready strobe, active low |
| prioHigh | input | NUM_EXT+1 | Group mask: 1 = high group, 0 = low group |
| gntN | output | NUM_EXT+1 | Grant per master, active low, at most one low |

## Verification
The bench builds the arbiter with four external masters (five in all) and the default 16-cycle timeout. With five masters, the rotation pointers wrap past the top index within a handful of transactions. Both the alternating-group mask and the all-high flat mask can be driven through complete rotations. The 16-cycle watchdog and the request-release that lifts the lockout fit in a short run, so every grant-gap, preemption and timeout path is reached cycle by cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Index width for master numbers; covers up to 16 masters.
  parameter int unsigned IDX_W = 4;

  // Strobes from the control half to the selection datapath.
  typedef struct packed {
    logic             reEval;   // a transaction has just started
    logic [IDX_W-1:0] starter;  // master that started it
  } arbStrobe_t;
endpackage

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int NUM_M = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_M-1:0] eligible,
  input  logic [NUM_M-1:0] prioHigh,
  input  arbStrobe_t       stb,
  output logic [IDX_W-1:0] winIdx,
  output logic             anyReq
);
  logic [IDX_W-1:0] ptrHi, ptrLo;
  logic             lastHi;
  logic             hiAny, loAny;
  logic [IDX_W-1:0] hiWin, loWin;

  function automatic logic [IDX_W-1:0] wrapIdx(logic [IDX_W-1:0] base, int step);
    logic [IDX_W:0] s;
    s = {1'b0, base} + (IDX_W+1)'(step);
    if (s >= (IDX_W+1)'(NUM_M)) s = s - (IDX_W+1)'(NUM_M);
    return s[IDX_W-1:0];
  endfunction

  // Scan each group from the entry after its pointer; walking backwards
  // lets the nearest hit overwrite farther ones.
  always_comb begin
    hiAny = 1'b0;
    loAny = 1'b0;
    hiWin = '0;
    loWin = '0;
    for (int k = NUM_M; k >= 1; k--) begin
      if (eligible[wrapIdx(ptrHi, k)] && prioHigh[wrapIdx(ptrHi, k)]) begin
        hiAny = 1'b1;
        hiWin = wrapIdx(ptrHi, k);
      end
      if (eligible[wrapIdx(ptrLo, k)] && !prioHigh[wrapIdx(ptrLo, k)]) begin
        loAny = 1'b1;
        loWin = wrapIdx(ptrLo, k);
      end
    end
  end

  logic pickHi;
  assign pickHi = hiAny && (!loAny || !lastHi);
  assign winIdx = pickHi ? hiWin : loWin;
  assign anyReq = hiAny || loAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHi  <= '0;
      ptrLo  <= '0;
      lastHi <= 1'b0;
    end else if (stb.reEval) begin
      if (prioHigh[stb.starter]) begin
        ptrHi  <= stb.starter;
        lastHi <= 1'b1;
      end else begin
        ptrLo  <= stb.starter;
        lastHi <= 1'b0;
      end
    end
  end

  // R3
  win_is_eligible_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> eligible[winIdx]);

  // R4
  group_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hiAny && loAny) |-> (prioHigh[winIdx] == !lastHi));
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int NUM_M   = 9,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_M-1:0] reqN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [IDX_W-1:0] winIdx,
  input  logic             anyReq,
  output logic [NUM_M-1:0] eligible,
  output arbStrobe_t       stb,
  output logic [NUM_M-1:0] gntN
);
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [IDX_W-1:0] owner, nOwner;
  logic             gntOn, nOn;
  logic [NUM_M-1:0] lock, nLock;
  logic [CNT_W-1:0] wdCnt;
  logic             frmPrev;
  logic             busIdle, wdCond, timeout;

  assign busIdle  = frameN && irdyN;
  assign eligible = ~reqN & ~lock;

  assign stb.reEval  = !frameN && frmPrev && gntOn;
  assign stb.starter = owner;

  assign wdCond  = gntOn && busIdle && !reqN[owner];
  assign timeout = wdCond && (wdCnt == CNT_W'(TIMEOUT - 1));

  always_comb begin
    nOn    = gntOn;
    nOwner = owner;
    if (timeout) begin
      nOn = 1'b0;
    end else if (anyReq) begin
      if (!gntOn) begin
        nOn    = 1'b1;
        nOwner = winIdx;
      end else if (winIdx != owner) begin
        if (busIdle) nOn = 1'b0;       // leave a dead cycle first
        else         nOwner = winIdx;  // busy bus: hand over directly
      end
    end
    nLock = lock & ~reqN;
    if (timeout) nLock[owner] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner   <= '0;
      gntOn   <= 1'b1;
      lock    <= '0;
      wdCnt   <= '0;
      frmPrev <= 1'b1;
    end else begin
      owner   <= nOwner;
      gntOn   <= nOn;
      lock    <= nLock;
      frmPrev <= frameN;
      if (timeout || !wdCond || (nOn != gntOn) || (nOwner != owner))
        wdCnt <= '0;
      else
        wdCnt <= wdCnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : gGnt
    assign gntN[g] = !(gntOn && (owner == IDX_W'(g)));
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN));

  // R8
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busIdle && (gntN != '1)) |=> ((gntN == $past(gntN)) || (gntN == '1)));

  // R7
  locked_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gntOn && lock[owner]));

  // R10
  park_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gntOn && !anyReq) |=> $stable(gntN));
endmodule

// File: rtl/dual_group_arbiter.sv
module dual_group_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_EXT = 8,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_EXT:0] reqN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [NUM_EXT:0] prioHigh,
  output logic [NUM_EXT:0] gntN
);
  // Index 0 is the local bridge master; NUM_M must not exceed 2**IDX_W.
  localparam int NUM_M = NUM_EXT + 1;

  logic [NUM_M-1:0] eligible;
  logic [IDX_W-1:0] winIdx;
  logic             anyReq;
  arbStrobe_t       stb;

  arb_select #(.NUM_M(NUM_M)) uSel (
    .clk(clk), .rstN(rstN), .eligible(eligible), .prioHigh(prioHigh),
    .stb(stb), .winIdx(winIdx), .anyReq(anyReq)
  );

  arb_ctrl #(.NUM_M(NUM_M), .TIMEOUT(TIMEOUT)) uCtrl (
    .clk(clk), .rstN(rstN), .reqN(reqN), .frameN(frameN), .irdyN(irdyN),
    .winIdx(winIdx), .anyReq(anyReq), .eligible(eligible), .stb(stb),
    .gntN(gntN)
  );
endmodule

// File: tb/tb_dual_group_arbiter.sv
module tb_dual_group_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NEXT = 4;
  localparam int M = NEXT + 1;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [M-1:0] reqN = '1;
  logic frameN = 1'b1;
  logic irdyN = 1'b1;
  logic [M-1:0] prioHigh = 5'b00001;
  logic [M-1:0] gntN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_group_arbiter #(.NUM_EXT(NEXT), .TIMEOUT(TMO)) dut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .frameN(frameN), .irdyN(irdyN),
    .prioHigh(prioHigh), .gntN(gntN)
  );

  task automatic chk(input bit ok, input string tag, input logic [M-1:0] act,
                     input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [M-1:0] only(input int idx);
    logic [M-1:0] v = '1;
    v[idx] = 1'b0;
    return v;
  endfunction

  // Behavioural reference model
  int mOwner, mCnt, mPtrH, mPtrL, hiW, loW, win, nOwner;
  bit mOn, mFrmPrev, mLastHi, nOn, idle, cond, tmo, startT;
  bit mLock [M];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOwner = 0; mOn = 1; mCnt = 0; mFrmPrev = 1;
      mPtrH = 0; mPtrL = 0; mLastHi = 0;
      for (int i = 0; i < M; i++) mLock[i] = 0;
    end else begin
      idle = frameN && irdyN;
      hiW = -1; loW = -1;
      for (int k = 1; k <= M; k++) begin
        int a;
        a = (mPtrH + k) % M;
        if (hiW < 0 && !reqN[a] && !mLock[a] && prioHigh[a]) hiW = a;
      end
      for (int k = 1; k <= M; k++) begin
        int b;
        b = (mPtrL + k) % M;
        if (loW < 0 && !reqN[b] && !mLock[b] && !prioHigh[b]) loW = b;
      end
      if (hiW >= 0 && (loW < 0 || !mLastHi)) win = hiW; else win = loW;
      startT = !frameN && mFrmPrev && mOn;
      cond = mOn && idle && !reqN[mOwner];
      tmo = cond && (mCnt == TMO - 1);
      nOn = mOn; nOwner = mOwner;
      if (tmo) nOn = 0;
      else if (win >= 0) begin
        if (!mOn) begin nOn = 1; nOwner = win; end
        else if (win != mOwner) begin
          if (idle) nOn = 0; else nOwner = win;
        end
      end
      for (int i = 0; i < M; i++) if (reqN[i]) mLock[i] = 0;
      if (tmo) mLock[mOwner] = 1;
      if (tmo || !cond || nOn != mOn || nOwner != mOwner) mCnt = 0; else mCnt++;
      if (startT) begin
        if (prioHigh[mOwner]) begin mPtrH = mOwner; mLastHi = 1; end
        else begin mPtrL = mOwner; mLastHi = 0; end
      end
      mFrmPrev = frameN; mOn = nOn; mOwner = nOwner;
    end
  end

  // Per-cycle comparison against the model (R1/R3/R4/R5/R6/R7/R8/R9/R10)
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [M-1:0] e;
      e = mOn ? only(mOwner) : '1;
      chk(gntN == e, "model R3/R5/R8/R9", gntN, e);
      chk($countones(~gntN) <= 1, "R1 one grant", gntN, e);
    end
  end

  task automatic xact();
    @(negedge clk); frameN = 1'b0; irdyN = 1'b0;
    @(negedge clk); frameN = 1'b1;
    @(negedge clk); irdyN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(gntN == only(0), "R2 reset park", gntN, only(0));
    repeat (4) @(negedge clk);
    chk(gntN == only(0), "R10 idle park", gntN, only(0));

    // Default mask: local high, externals low; 0,1,2 request
    reqN = 5'b11000;
    repeat (2) @(negedge clk);
    chk(gntN == only(0), "R4 local first", gntN, only(0));
    xact(); chk(gntN == only(1), "R4 low turn", gntN, only(1));
    xact(); chk(gntN == only(0), "R4 local turn", gntN, only(0));
    xact(); chk(gntN == only(2), "R5 low rotates", gntN, only(2));
    xact(); chk(gntN == only(0), "R4 local again", gntN, only(0));
    xact(); chk(gntN == only(1), "R5 wrap", gntN, only(1));

    reqN = '1;
    repeat (5) @(negedge clk);
    chk(gntN == only(1), "R10 park last", gntN, only(1));

    // Flat round robin
    prioHigh = '1;
    reqN = 5'b00101;
    repeat (2) @(negedge clk);
    chk(gntN == only(1), "R6 hold", gntN, only(1));
    xact(); chk(gntN == only(3), "R6 next", gntN, only(3));
    xact(); chk(gntN == only(4), "R6 next2", gntN, only(4));
    xact(); chk(gntN == only(1), "R6 wrap", gntN, only(1));

    // Preemption on a busy bus
    reqN = 5'b11101;
    repeat (2) @(negedge clk);
    reqN = 5'b11100; irdyN = 1'b0;
    @(negedge clk);
    chk(gntN == only(0), "R3/R9 preempt busy", gntN, only(0));

    // Idle handover with gap
    irdyN = 1'b1; reqN = 5'b11101;
    @(negedge clk);
    chk(gntN == '1, "R8 gap", gntN, '1);
    @(negedge clk);
    chk(gntN == only(1), "R8 after gap", gntN, only(1));

    // Watchdog
    repeat (TMO - 1) @(negedge clk);
    chk(gntN == only(1), "R7 before timeout", gntN, only(1));
    @(negedge clk);
    chk(gntN == '1, "R7 timeout", gntN, '1);
    repeat (4) @(negedge clk);
    chk(gntN == '1, "R7 lockout", gntN, '1);
    reqN = '1;
    @(negedge clk);
    reqN = 5'b11101;
    @(negedge clk);
    chk(gntN == only(1), "R7 unlock", gntN, only(1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule